// File: doc/BRIEF.md
# SDRAM Bank Command State Tracker

This block watches the control pins of a synchronous DRAM bus. On every rising clock edge it samples the chip select, row strobe, column strobe and write enable pins. It turns them into one of eight commands and keeps a state machine for each of four banks. A bank can be idle, open (a row is active), reading or writing. The block is meant to sit beside a memory controller or a bus monitor, and to report at once any command that the addressed bank cannot accept in its present state.

Read and write bursts are counted against a programmed burst length that is sampled when the burst starts. When the count runs out, the bank falls back to the open state. A precharge, a burst terminate or a new column command can cut a burst short or restart it. A precharge with the all-banks address bit set closes every bank. The decoded command and the illegal flag are registered, so they appear in the cycle after the edge that sampled the pins, together with the updated bank states.

Top module: `sdram_bank_tracker`

## Requirements
- R1: After reset every bank is idle (state code 0), `cmd_o` is NOP (code 0) and `illegal_o` is 0.
- R2: With `cs_n` low, the pins {ras_n, cas_n, we_n} decode as follows: 111 to NOP (0), 011 to ACTIVE (1), 001 to AUTO REFRESH (2), 000 to LOAD MODE (3), 010 to PRECHARGE (4), 101 to READ (5), 100 to WRITE (6) and 110 to BURST TERMINATE (7). The code appears on `cmd_o` after the sampling edge.
- R3: With `cs_n` high the cycle decodes as NOP whatever the other pins are. It is never illegal, and any burst in progress keeps counting.
- R4: ACTIVE is legal only on an idle bank, which then becomes open (code 1). ACTIVE on a bank that is not idle is illegal.
- R5: READ and WRITE are illegal on an idle bank. On an open, reading or writing bank they are legal: the bank enters reading (code 2) or writing (code 3) and its burst count restarts.
- R6: A burst shows its reading or writing state for exactly L cycles, starting with the cycle after the command edge, and the bank then becomes open. L is `burst_len_i` sampled at the command, and a value of 0 counts as 1.
- R7: PRECHARGE to a single bank is legal in every state and makes that bank idle, which truncates any burst in it.
- R8: PRECHARGE with `all_banks_i` set is legal and makes all four banks idle, whatever `bank_i` holds.
- R9: BURST TERMINATE is legal only on a reading or writing bank, which becomes open. On an idle or open bank it is illegal.
- R10: AUTO REFRESH and LOAD MODE are legal only when all banks are idle, and they change no bank state.
- R11: An illegal command leaves the state of its addressed bank unchanged, apart from the normal countdown of a burst already running there.
- R12: Each bank keeps its own burst count, so bursts in different banks run and end independently of commands sent to other banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select pin sample, active low |
| ras_n | input | 1 | Row strobe pin sample, active low |
| cas_n | input | 1 | Column strobe pin sample, active low |
| we_n | input | 1 | Write enable pin sample, active low |
| bank_i | input | 2 | Bank address for the command |
| all_banks_i | input | 1 | All-banks bit for PRECHARGE |
| burst_len_i | input | 4 | Programmed burst length, 0 counts as 1 |
| cmd_o | output | 3 | Registered decoded command code |
| bank_state_o | output | 8 | Two bits per bank, bank b at [2b+1:2b] |
| illegal_o | output | 1 | Registered flag: the sampled command was illegal |

## Verification
Directed sequences step one bank through every state with each command. They separate legal from illegal pairs, such as a second ACTIVE, a READ to an idle bank, a BURST TERMINATE to an open bank, and AUTO REFRESH with a bank open. Burst sequences with lengths of 3 and 0 pin down the exact cycle in which a bank returns to open, and show how a precharge or terminate truncates the burst. Overlapping bursts in two banks, with a chip-deselected cycle in the middle, show that the counts are kept per bank. A long run of weighted random commands, bank numbers and burst lengths, checked every cycle against a bench model, covers state and command pairs that the directed cases miss.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_REF = 3'd2,
    CMD_LMR = 3'd3,
    CMD_PRE = 3'd4,
    CMD_RD  = 3'd5,
    CMD_WR  = 3'd6,
    CMD_BST = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE = 2'd0,
    BK_OPEN = 2'd1,
    BK_RD   = 2'd2,
    BK_WR   = 2'd3
  } bank_e;

  // Pin decode (R2, R3): deselect is a no-op
  function automatic cmd_e decode_pins(input logic cs_n, input logic ras_n,
                                       input logic cas_n, input logic we_n);
    cmd_e c;
    if (cs_n) begin
      c = CMD_NOP;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b011:  c = CMD_ACT;
        3'b001:  c = CMD_REF;
        3'b000:  c = CMD_LMR;
        3'b010:  c = CMD_PRE;
        3'b101:  c = CMD_RD;
        3'b100:  c = CMD_WR;
        3'b110:  c = CMD_BST;
        default: c = CMD_NOP;
      endcase
    end
    return c;
  endfunction

  // Commands that address one bank
  function automatic logic is_bank_cmd(input cmd_e c);
    return (c == CMD_ACT) || (c == CMD_PRE) || (c == CMD_RD) ||
           (c == CMD_WR)  || (c == CMD_BST);
  endfunction

  function automatic logic in_burst(input bank_e s);
    return (s == BK_RD) || (s == BK_WR);
  endfunction

  // Legality of a command against the addressed bank state
  function automatic logic cmd_legal(input cmd_e c, input bank_e s,
                                     input logic all_idle);
    logic ok;
    case (c)
      CMD_NOP:         ok = 1'b1;
      CMD_ACT:         ok = (s == BK_IDLE);
      CMD_REF, CMD_LMR: ok = all_idle;
      CMD_PRE:         ok = 1'b1;
      CMD_RD, CMD_WR:  ok = (s != BK_IDLE);
      CMD_BST:         ok = in_burst(s);
      default:         ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_trk_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd_o,
  output logic bank_cmd_o
);

  always_comb begin
    cmd_o      = decode_pins(cs_n, ras_n, cas_n, we_n);
    bank_cmd_o = is_bank_cmd(cmd_o);
  end

endmodule

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
  import sdram_trk_pkg::*;
#(
  parameter int BL_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            apply_i,
  input  cmd_e            cmd_i,
  input  logic [BL_W-1:0] burst_len_i,
  output bank_e           state_o
);

  bank_e           state_q;
  logic [BL_W-1:0] left_q;
  logic [BL_W-1:0] start_len;
  logic            burst_end;

  assign start_len = (burst_len_i == '0) ? BL_W'(1) : burst_len_i;
  assign burst_end = !apply_i && in_burst(state_q) && (left_q <= BL_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= BK_IDLE;
      left_q  <= '0;
    end else if (apply_i) begin
      case (cmd_i)
        CMD_ACT: state_q <= BK_OPEN;
        CMD_PRE: begin state_q <= BK_IDLE; left_q <= '0; end
        CMD_BST: begin state_q <= BK_OPEN; left_q <= '0; end
        CMD_RD:  begin state_q <= BK_RD;   left_q <= start_len; end
        CMD_WR:  begin state_q <= BK_WR;   left_q <= start_len; end
        default: ;
      endcase
    end else if (burst_end) begin
      state_q <= BK_OPEN;
      left_q  <= '0;
    end else if (in_burst(state_q)) begin
      left_q <= left_q - BL_W'(1);
    end
  end

  assign state_o = state_q;

  assert_pre_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    apply_i && cmd_i == CMD_PRE |=> state_q == BK_IDLE);

  assert_bst_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
    apply_i && cmd_i == CMD_BST |=> state_q == BK_OPEN);

  assert_burst_end_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    burst_end |=> state_q == BK_OPEN);

  assert_no_burst_from_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == BK_IDLE |=> !in_burst(state_q));

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = $clog2(NUM_BANKS),
  parameter int BL_W      = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   ras_n,
  input  logic                   cas_n,
  input  logic                   we_n,
  input  logic [BA_W-1:0]        bank_i,
  input  logic                   all_banks_i,
  input  logic [BL_W-1:0]        burst_len_i,
  output logic [2:0]             cmd_o,
  output logic [2*NUM_BANKS-1:0] bank_state_o,
  output logic                   illegal_o
);

  cmd_e                 cur_cmd;
  logic                 cur_bank_cmd;
  bank_e                st [NUM_BANKS];
  logic [NUM_BANKS-1:0] idle_vec;
  logic                 all_idle;
  bank_e                tgt_state;
  logic                 cur_legal;
  logic [BA_W-1:0]      bank_q;
  cmd_e                 cmd_q;
  logic                 illegal_q;
  bank_e                q_tgt_state;

  sdram_cmd_decode u_dec (
    .cs_n       (cs_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .cmd_o      (cur_cmd),
    .bank_cmd_o (cur_bank_cmd)
  );

  assign all_idle  = &idle_vec;
  assign tgt_state = st[bank_i];
  assign cur_legal = cmd_legal(cur_cmd, tgt_state, all_idle);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (cur_cmd == CMD_PRE && all_banks_i) ||
                 (cur_bank_cmd && bank_i == BA_W'(b));

    sdram_bank_fsm #(.BL_W(BL_W)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .apply_i     (hit && cur_legal),
      .cmd_i       (cur_cmd),
      .burst_len_i (burst_len_i),
      .state_o     (st[b])
    );

    assign bank_state_o[2*b +: 2] = st[b];
    assign idle_vec[b]            = (st[b] == BK_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q     <= CMD_NOP;
      illegal_q <= 1'b0;
      bank_q    <= '0;
    end else begin
      cmd_q     <= cur_cmd;
      illegal_q <= !cur_legal;
      bank_q    <= bank_i;
    end
  end

  assign cmd_o       = cmd_q;
  assign illegal_o   = illegal_q;
  assign q_tgt_state = st[bank_q];

  assert_inhibit_nop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (cmd_o == CMD_NOP) && !illegal_o);

  assert_act_opens_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_o == CMD_ACT && !illegal_o |-> q_tgt_state == BK_OPEN);

  assert_global_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_REF || cmd_o == CMD_LMR) && !illegal_o |-> all_idle);

  assert_pre_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cur_cmd == CMD_PRE && all_banks_i |=> all_idle && !illegal_o);

endmodule

// File: tb/sdram_bank_tracker_test.sv
module sdram_bank_tracker_test;

  localparam int NB = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] bank_i = '0;
  logic       all_banks_i = 1'b0;
  logic [3:0] burst_len_i = 4'd3;
  logic [2:0] cmd_o;
  logic [7:0] bank_state_o;
  logic       illegal_o;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  // bench model
  int m_st [NB];
  int m_left [NB];

  sdram_bank_tracker uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .bank_i(bank_i), .all_banks_i(all_banks_i),
    .burst_len_i(burst_len_i), .cmd_o(cmd_o), .bank_state_o(bank_state_o),
    .illegal_o(illegal_o)
  );

  always #10 clk = ~clk;

  task automatic check_eq(input string tag, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // pins {ras,cas,we} per command code (R2)
  function automatic logic [2:0] pins_of(input int c);
    case (c)
      1: return 3'b011; 2: return 3'b001; 3: return 3'b000; 4: return 3'b010;
      5: return 3'b101; 6: return 3'b100; 7: return 3'b110;
      default: return 3'b111;
    endcase
  endfunction

  // allowed-state mask per command, bit s = state s allowed
  function automatic bit exp_ok(input int c, input int b);
    bit idle_all = 1;
    for (int k = 0; k < NB; k++) if (m_st[k] != 0) idle_all = 0;
    case (c)
      1: return m_st[b] == 0;
      2, 3: return idle_all;
      5, 6: return ((4'b1110 >> m_st[b]) & 1) != 0;
      7: return ((4'b1100 >> m_st[b]) & 1) != 0;
      default: return 1;
    endcase
  endfunction

  // c = -1 means deselect (cs_n high, random other pins)
  task automatic step(input int c, input int b, input bit all, input string tag);
    int  ec;
    bit  ok;
    int  len;
    @(negedge clk);
    if (c < 0) begin
      cs_n = 1'b1;
      {ras_n, cas_n, we_n} = 3'($urandom);
      ec = 0;
    end else begin
      cs_n = 1'b0;
      {ras_n, cas_n, we_n} = pins_of(c);
      ec = c;
    end
    bank_i      = 2'(b);
    all_banks_i = all;
    ok  = exp_ok(ec, b);
    len = (burst_len_i == 0) ? 1 : int'(burst_len_i);
    for (int k = 0; k < NB; k++) begin
      bit tgt = (ec == 4 && all) || (k == b && ec inside {1, 4, 5, 6, 7});
      if (ok && tgt) begin
        case (ec)
          1: m_st[k] = 1;
          4: begin m_st[k] = 0; m_left[k] = 0; end
          5: begin m_st[k] = 2; m_left[k] = len; end
          6: begin m_st[k] = 3; m_left[k] = len; end
          7: begin m_st[k] = 1; m_left[k] = 0; end
          default: ;
        endcase
      end else if (m_st[k] >= 2) begin
        if (m_left[k] <= 1) begin m_st[k] = 1; m_left[k] = 0; end
        else m_left[k]--;
      end
    end
    @(posedge clk);
    #2;
    check_eq(tag, "cmd_o", int'(cmd_o), ec);
    check_eq(tag, "illegal_o", int'(illegal_o), ok ? 0 : 1);
    for (int k = 0; k < NB; k++)
      check_eq(tag, $sformatf("bank%0d state", k), int'(bank_state_o[2*k +: 2]), m_st[k]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < NB; k++) begin m_st[k] = 0; m_left[k] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_eq("R1", "cmd_o", int'(cmd_o), 0);
    check_eq("R1", "illegal_o", int'(illegal_o), 0);
    check_eq("R1", "bank_state_o", int'(bank_state_o), 0);

    burst_len_i = 4'd3;
    step(-1, 2, 0, "R3");
    step(1, 0, 0, "R4");
    step(1, 0, 0, "R4");
    step(5, 1, 0, "R5");
    step(5, 0, 0, "R5");
    step(0, 0, 0, "R6");
    step(0, 0, 0, "R6");
    step(0, 0, 0, "R6");
    step(6, 0, 0, "R5");
    step(7, 0, 0, "R9");
    step(7, 0, 0, "R9");
    step(2, 0, 0, "R10");
    step(3, 0, 0, "R10");
    step(1, 1, 0, "R12");
    step(5, 0, 0, "R12");
    step(6, 1, 0, "R12");
    step(-1, 3, 0, "R3");
    step(1, 1, 0, "R11");
    step(4, 0, 0, "R7");
    step(0, 0, 0, "R12");
    step(5, 1, 0, "R5");
    step(4, 2, 1, "R8");
    step(2, 0, 0, "R10");
    step(3, 3, 0, "R10");
    step(7, 2, 0, "R9");
    burst_len_i = 4'd0;
    step(1, 2, 0, "R4");
    step(5, 2, 0, "R6");
    step(0, 2, 0, "R6");
    burst_len_i = 4'd2;
    step(6, 2, 0, "R6");
    step(4, 2, 0, "R7");

    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom % 20);
      int c;
      if (i % 40 == 0) burst_len_i = 4'($urandom % 8);
      if (r < 2) c = -1;
      else if (r < 5) c = 0;
      else if (r < 9) c = 1;
      else if (r < 12) c = 5;
      else if (r < 14) c = 6;
      else if (r < 16) c = 4;
      else if (r < 18) c = 7;
      else c = 2 + (r & 1);
      step(c, int'($urandom % 4), ($urandom % 6) == 0, "R2");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule